// File: doc/BRIEF.md
# Boot Image Loader with CRC-32 Check

This block sits between a byte-wide boot source and the instruction RAM of a processor tile. It takes bytes over a valid/ready handshake, reads a little-endian word count from the first four bytes, and then packs the program bytes into 32-bit words. Each complete word is written to RAM, starting at word address 0 and counting upward. Four more bytes follow the program. They hold the expected checksum.

A CRC-32 engine runs over the count bytes and the program bytes as they arrive, at one byte per accepted cycle. When the last trailer byte arrives, the block compares the trailer with the inverted CRC register. If they match, or if the trailer holds the skip-check marker, the block signals completion and pulses a start request with entry address 0. If they differ, the block raises a checksum error instead. A word count larger than the RAM depth stops the load as soon as the count is known.

The loader handles one image per reset. After it finishes, it refuses further input until the next reset.

Top module: `boot_image_loader`

## Requirements
- R1: After reset, `in_ready` is 1 and `done`, `start`, `crc_error`, `size_error` and `ram_we` are 0.
- R2: The first four accepted bytes form the word count N, least significant byte first.
- R3: Program bytes are packed least significant byte first into 32-bit words. There is exactly one RAM write per complete word, and consecutive writes use ascending addresses 0, 1, 2 and so on.
- R4: Exactly N words are written. With N = 0 no write occurs, and the next four bytes are taken as the trailer.
- R5: The checksum is CRC-32 with reflected polynomial 0xEDB88320, initial value 0xFFFFFFFF and an inverted result. It covers the four count bytes and the program bytes, and not the trailer. When the little-endian trailer equals this value, `done` rises and `start` pulses for exactly one cycle, with `start_addr` = 0.
- R6: When the trailer differs from the checksum and is not the skip marker, `crc_error` and `done` go to 1 and `start` never pulses.
- R7: A trailer equal to 0x0D15AB1E is accepted whatever the checksum, and `start` pulses.
- R8: If N > RAM_DEPTH, then `size_error` and `done` are set on the cycle after the fourth count byte is accepted. No RAM write occurs, `start` never pulses, and `in_ready` drops.
- R9: Once `done` is 1, `in_ready` stays 0 and no further input causes a RAM write or changes any status output.
- R10: A byte is consumed only in a cycle where `in_valid` and `in_ready` are both 1. Idle cycles between bytes change nothing.
- R11: `done`, together with `start` or `crc_error`, is visible in the cycle right after the clock edge that accepted the final trailer byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Incoming image byte |
| in_valid | input | 1 | `in_data` holds a byte |
| in_ready | output | 1 | Loader can accept a byte |
| ram_we | output | 1 | RAM write strobe, one cycle per word |
| ram_addr | output | AW | RAM word address |
| ram_wdata | output | 32 | RAM write data |
| done | output | 1 | Load finished (sticky) |
| start | output | 1 | One-cycle request to start execution |
| start_addr | output | AW | Entry address for execution, always 0 |
| crc_error | output | 1 | Checksum mismatch (sticky) |
| size_error | output | 1 | Word count exceeds RAM depth (sticky) |

## Verification
Several properties are checked on every cycle:
- `in_ready` stays low once the load has finished.
- A checksum error never coincides with a start request.
- Start is a single-cycle pulse that always comes together with `done`.
- RAM writes are never back to back.
- An oversize count never produces a write.
- `done` rises only right after an accepted byte.

Other behaviour only the bench scenarios can show:
- the CRC value itself;
- little-endian word packing;
- exact write counts for empty, single-word and full-depth images;
- the skip marker;
- oversize rejection;
- correct results under random stalls in the byte stream.

// File: rtl/bil_pkg.sv
package bil_pkg;
  localparam logic [31:0] CRC_POLY_R = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED   = 32'hFFFF_FFFF;
  localparam logic [31:0] SKIP_TOKEN = 32'h0D15_AB1E;

  typedef enum logic [1:0] {
    PH_COUNT = 2'd0,
    PH_BODY  = 2'd1,
    PH_TAIL  = 2'd2,
    PH_HALT  = 2'd3
  } phase_t;

  // One byte through the reflected CRC register, lowest bit first.
  function automatic logic [31:0] crc_byte_step(input logic [31:0] acc,
                                                input logic [7:0]  din);
    logic [31:0] r;
    r = acc ^ {24'd0, din};
    for (int i = 0; i < 8; i++) begin
      if (r[0]) r = (r >> 1) ^ CRC_POLY_R;
      else      r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/bil_crc32.sv
module bil_crc32
  import bil_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] result
);
  logic [31:0] acc_q;

  always_ff @(posedge clk) begin
    if (rst)     acc_q <= CRC_SEED;
    else if (en) acc_q <= crc_byte_step(acc_q, din);
  end

  assign result = ~acc_q;
endmodule

// File: rtl/bil_word_packer.sv
module bil_word_packer #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [7:0]    din,
  output logic          word_done,
  output logic          we,
  output logic [AW-1:0] addr,
  output logic [31:0]   wdata
);
  logic [1:0]    lane_q;
  logic [23:0]   part_q;
  logic [AW-1:0] next_q;

  assign word_done = en && (lane_q == 2'd3);

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_q <= 2'd0;
      part_q <= 24'd0;
      next_q <= '0;
      we     <= 1'b0;
      addr   <= '0;
      wdata  <= 32'd0;
    end else begin
      we <= 1'b0;
      if (en) begin
        lane_q <= lane_q + 2'd1;
        part_q <= {din, part_q[23:8]};
        if (lane_q == 2'd3) begin
          we     <= 1'b1;
          addr   <= next_q;
          wdata  <= {din, part_q};
          next_q <= next_q + 1'b1;
        end
      end
    end
  end

  // R3: a word needs four bytes, so write strobes can never be adjacent
  a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
    we |=> !we);
endmodule

// File: rtl/bil_ctrl.sv
module bil_ctrl
  import bil_pkg::*;
#(
  parameter int RAM_DEPTH = 1024,
  parameter int CW        = 11
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  in_data,
  input  logic        in_valid,
  input  logic        word_done,
  input  logic [31:0] crc_value,
  output logic        in_ready,
  output logic        crc_en,
  output logic        pack_en,
  output logic        done,
  output logic        start,
  output logic        crc_error,
  output logic        size_error
);
  phase_t        ph_q;
  logic [1:0]    lane_q;
  logic [23:0]   hold_q;
  logic [CW-1:0] left_q;
  logic          ready_q;
  logic          accept;
  logic [31:0]   full_word;

  assign in_ready  = ready_q;
  assign accept    = in_valid && ready_q;
  assign full_word = {in_data, hold_q};
  assign crc_en    = accept && (ph_q == PH_COUNT || ph_q == PH_BODY);
  assign pack_en   = accept && (ph_q == PH_BODY);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q       <= PH_COUNT;
      lane_q     <= 2'd0;
      hold_q     <= 24'd0;
      left_q     <= '0;
      ready_q    <= 1'b1;
      done       <= 1'b0;
      start      <= 1'b0;
      crc_error  <= 1'b0;
      size_error <= 1'b0;
    end else begin
      start <= 1'b0;
      unique case (ph_q)
        PH_COUNT: if (accept) begin
          lane_q <= lane_q + 2'd1;
          hold_q <= {in_data, hold_q[23:8]};
          if (lane_q == 2'd3) begin
            if (full_word > 32'(RAM_DEPTH)) begin
              size_error <= 1'b1;
              done       <= 1'b1;
              ready_q    <= 1'b0;
              ph_q       <= PH_HALT;
            end else if (full_word == 32'd0) begin
              ph_q <= PH_TAIL;
            end else begin
              left_q <= full_word[CW-1:0];
              ph_q   <= PH_BODY;
            end
          end
        end
        PH_BODY: if (word_done) begin
          left_q <= left_q - 1'b1;
          if (left_q == CW'(1)) ph_q <= PH_TAIL;
        end
        PH_TAIL: if (accept) begin
          lane_q <= lane_q + 2'd1;
          hold_q <= {in_data, hold_q[23:8]};
          if (lane_q == 2'd3) begin
            done    <= 1'b1;
            ready_q <= 1'b0;
            ph_q    <= PH_HALT;
            if (full_word == SKIP_TOKEN || full_word == crc_value) start <= 1'b1;
            else                                                    crc_error <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // R9: once finished, the input side stays closed
  a_r9_closed_after_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !in_ready);
  // R6: a checksum error never comes with a start request
  a_r6_no_start_on_error: assert property (@(posedge clk) disable iff (rst)
    crc_error |-> !start);
  // R5: start lasts a single cycle
  a_r5_start_one_cycle: assert property (@(posedge clk) disable iff (rst)
    start |=> !start);
  // R5: start comes with done
  a_r5_start_with_done: assert property (@(posedge clk) disable iff (rst)
    start |-> done);
  // R11: done rises only after an accepted byte
  a_r11_done_after_byte: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(in_valid && in_ready));
  // R4: the body phase always has words outstanding
  a_r4_body_nonempty: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_BODY) |-> (left_q != '0));
endmodule

// File: rtl/boot_image_loader.sv
module boot_image_loader #(
  parameter int RAM_DEPTH = 1024,
  localparam int AW = (RAM_DEPTH > 1) ? $clog2(RAM_DEPTH) : 1,
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [7:0]    in_data,
  input  logic          in_valid,
  output logic          in_ready,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [31:0]   ram_wdata,
  output logic          done,
  output logic          start,
  output logic [AW-1:0] start_addr,
  output logic          crc_error,
  output logic          size_error
);
  logic        crc_en;
  logic        pack_en;
  logic        word_done;
  logic [31:0] crc_value;

  assign start_addr = '0;

  bil_crc32 u_crc (
    .clk    (clk),
    .rst    (rst),
    .en     (crc_en),
    .din    (in_data),
    .result (crc_value)
  );

  bil_word_packer #(.AW(AW)) u_pack (
    .clk       (clk),
    .rst       (rst),
    .en        (pack_en),
    .din       (in_data),
    .word_done (word_done),
    .we        (ram_we),
    .addr      (ram_addr),
    .wdata     (ram_wdata)
  );

  bil_ctrl #(.RAM_DEPTH(RAM_DEPTH), .CW(CW)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .in_data    (in_data),
    .in_valid   (in_valid),
    .word_done  (word_done),
    .crc_value  (crc_value),
    .in_ready   (in_ready),
    .crc_en     (crc_en),
    .pack_en    (pack_en),
    .done       (done),
    .start      (start),
    .crc_error  (crc_error),
    .size_error (size_error)
  );

  // R8: an oversize count never leads to a RAM write
  a_r8_no_write_on_oversize: assert property (@(posedge clk) disable iff (rst)
    size_error |-> !ram_we);
endmodule

// File: tb/boot_image_loader_test.sv
module boot_image_loader_test;
  localparam int DEPTH = 1024;
  localparam int AW    = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [7:0]    in_data = 8'd0;
  logic          in_valid = 1'b0;
  logic          in_ready, ram_we, done, start, crc_error, size_error;
  logic [AW-1:0] ram_addr, start_addr;
  logic [31:0]   ram_wdata;

  boot_image_loader #(.RAM_DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .done(done), .start(start),
    .start_addr(start_addr), .crc_error(crc_error), .size_error(size_error));

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [7:0]  img [0:4111];
  logic [31:0] words [0:DEPTH];
  logic [31:0] mram [0:DEPTH-1];
  int wr_count, addr_bad, start_count, start_addr_bad;
  bit mon_on = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r = c;
    for (int k = 0; k < 8; k++) begin
      logic fb = r[0] ^ b[k];
      r = {1'b0, r[31:1]};
      if (fb) r = r ^ 32'hEDB88320;
    end
    return r;
  endfunction

  always @(negedge clk) begin
    if (mon_on && !rst) begin
      if (ram_we) begin
        if (32'(ram_addr) != 32'(wr_count)) addr_bad++;
        mram[ram_addr] = ram_wdata;
        wr_count++;
      end
      if (start) begin
        start_count++;
        if (start_addr != '0) start_addr_bad++;
      end
    end
  end

  task automatic do_reset();
    mon_on = 0;
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    wr_count = 0; addr_bad = 0; start_count = 0; start_addr_bad = 0;
    rst = 1'b0;
    mon_on = 1;
  endtask

  // Sends bytes img[first..first+n-1] with random stalls (R10); returns after
  // the posedge that accepted the last one.
  task automatic send(input int first, input int n, input bit gaps);
    int idx = first;
    while (idx < first + n) begin
      bit took;
      @(negedge clk);
      in_valid = gaps ? (($urandom % 4) != 0) : 1'b1;
      in_data  = in_valid ? img[idx] : 8'($urandom);
      took = in_valid && in_ready;
      @(posedge clk);
      if (took) idx++;
      if (!in_ready) break;
    end
    #1 in_valid = 1'b0;
  endtask

  // mode 0: good CRC, 1: corrupted CRC, 2: skip marker
  task automatic run_image(input int n, input int mode, input string tag);
    logic [31:0] c = 32'hFFFF_FFFF;
    logic [31:0] trl;
    int total;
    bit expect_ok;
    do_reset();
    img[0] = n[7:0]; img[1] = n[15:8]; img[2] = n[23:16]; img[3] = n[31:24];
    for (int i = 0; i < n; i++) begin
      words[i] = $urandom;
      for (int k = 0; k < 4; k++) img[4 + 4*i + k] = words[i][8*k +: 8];
    end
    for (int i = 0; i < 4 + 4*n; i++) c = ref_crc(c, img[i]);
    c = ~c;
    trl = (mode == 0) ? c : (mode == 1) ? (c ^ (32'd1 << ($urandom % 32))) : 32'h0D15AB1E;
    expect_ok = (mode != 1);
    total = 4 + 4*n;
    for (int k = 0; k < 4; k++) img[total + k] = trl[8*k +: 8];
    send(0, total + 4, 1'b1);
    @(negedge clk);
    // R11: results visible right after the accepting edge
    chk(done == 1'b1, "R11", {tag, " done"}, done, 1);
    chk(start == expect_ok, expect_ok ? "R5" : "R6", {tag, " start pulse"}, start, expect_ok);
    chk(crc_error == !expect_ok, expect_ok ? "R7" : "R6", {tag, " crc_error"}, crc_error, !expect_ok);
    @(negedge clk);
    chk(start == 1'b0, "R5", {tag, " start one cycle"}, start, 0);
    // R9: further bytes offered are refused
    in_valid = 1'b1; in_data = 8'hA5;
    repeat (4) @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R9", {tag, " ready after done"}, in_ready, 0);
    chk(start_count == int'(expect_ok), "R5", {tag, " start count"}, start_count, expect_ok);
    chk(start_addr_bad == 0, "R5", {tag, " start addr"}, start_addr_bad, 0);
    // R4 / R2: exactly N writes
    chk(wr_count == n, "R4", {tag, " write count"}, wr_count, n);
    chk(addr_bad == 0, "R3", {tag, " ascending addresses"}, addr_bad, 0);
    begin
      int bad = 0, first_bad = -1;
      for (int i = 0; i < n; i++)
        if (mram[i] !== words[i]) begin bad++; if (first_bad < 0) first_bad = i; end
      // R3 / R10: little-endian packing survives random stalls
      chk(bad == 0, "R3", {tag, " word contents"},
          (first_bad < 0) ? 0 : mram[first_bad], (first_bad < 0) ? 0 : words[first_bad]);
    end
  endtask

  initial begin
    int s;
    s = $urandom(32'd20240611);
    do_reset();
    @(negedge clk);
    // R1: reset state
    chk(in_ready == 1'b1, "R1", "ready after reset", in_ready, 1);
    chk({done, start, crc_error, size_error, ram_we} == 5'd0, "R1", "outputs idle after reset",
        {done, start, crc_error, size_error, ram_we}, 0);

    run_image(1, 0, "one word");
    run_image(0, 0, "empty good");
    run_image(0, 2, "empty skip");
    run_image(0, 1, "empty bad");
    for (int t = 0; t < 4; t++) run_image(1 + int'($urandom % 150), 0, "random good");
    for (int t = 0; t < 3; t++) run_image(1 + int'($urandom % 100), 1, "random bad");
    run_image(37, 2, "skip marker");
    run_image(DEPTH, 0, "full depth");

    // R8: oversize count
    do_reset();
    img[0] = 8'(DEPTH + 1); img[1] = 8'((DEPTH + 1) >> 8); img[2] = 8'd0; img[3] = 8'd0;
    send(0, 4, 1'b1);
    @(negedge clk);
    chk(size_error == 1'b1 && done == 1'b1, "R8", "oversize flagged", {size_error, done}, 3);
    chk(in_ready == 1'b0, "R8", "ready drops on oversize", in_ready, 0);
    in_valid = 1'b1; in_data = 8'h11;
    repeat (12) @(negedge clk);
    in_valid = 1'b0;
    chk(wr_count == 0 && start_count == 0, "R8", "no write or start on oversize",
        wr_count + start_count, 0);
    chk(crc_error == 1'b0, "R9", "status unchanged after done", crc_error, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(150000 * 20);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule